// File: doc/BRIEF.md
# Stereo Serial Audio Output Port

This block drives the serial stereo output of an audio sample path. In master mode a free-running counter divides a system clock, which runs at 512 times the output sample rate, into a frame clock and a bit clock. The bit clock runs at 64 periods per frame in every format. In slave mode both clocks come from outside and are sampled into the system clock domain. Each 20-bit left or right sample is taken in parallel at the start of its channel word. It is then sent MSB-first in one of five layouts, chosen by two format straps and an I2S select.

Muting always acts on whole words. After reset the first eight channel words are zero. The mute input is sampled at each word boundary. A through mode bypasses the serializer and connects an upstream serial port directly to the outputs, whatever the format straps say. The mute input still forces the data line low in through mode.

Top module: `aout_port`

## Requirements
- R1: While rst_ni is low and through mode is off, dat_o, frm_o and bck_o are all low, and clk_oe_o is high when slave_i is low.
- R2: In master mode, bck_o has a period of 8 system clocks (4 high, 4 low), and frm_o has a period of 512 system clocks (256 high, 256 low), so each frame holds 64 bit clock rises.
- R3: frm_o changes only while bck_o is low. Outside I2S, frm_o high marks the left word. With I2S, frm_o low marks the left word. After reset, the left word comes first.
- R4: In master mode, dat_o changes only on the clock in which bck_o falls, so a receiver can sample it on the bit clock rise.
- R5: Slots 0 to 31 of each channel word are numbered from the frame edge. fmt_i=00 gives 16-bit right-justified (MSB in slot 16). fmt_i=01 gives 20-bit right-justified (MSB in slot 12). fmt_i=10 gives 24-bit right-justified (MSB in slot 8, followed by the 20 sample bits and then four zero bits). fmt_i=11 gives 16-bit left-justified (MSB in slot 0). i2s_i=1 selects 16-bit I2S (MSB in slot 1) whatever fmt_i is. The 16-bit layouts send the upper 16 sample bits. Every other slot is zero.
- R6: After reset is released, the first 8 channel words are all zero. Sample data begins with the ninth word, which is a left word.
- R7: mute_i is sampled at each word boundary. Raising it zeroes the data from the next word onward, and the word in progress finishes unchanged. Lowering it restores data from the next word onward.
- R8: With slave_i high and thru_i low, the word timing follows ext_frm_i and ext_bck_i with the same layouts as master mode, and frm_o, bck_o and clk_oe_o are held low.
- R9: With thru_i high, frm_o, bck_o and dat_o follow in_frm_i, in_bck_i and in_dat_i combinationally, regardless of fmt_i and i2s_i, and clk_oe_o is high.
- R10: With thru_i high, dat_o is low whenever mute_i is high or rst_ni is low. The clocks still pass through.
- R11: Each channel's sample is captured from left_i or right_i at slot 0 of its word. Changes to those inputs later in the word do not affect that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, 512 x output sample rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Format straps (see R5) |
| i2s_i | input | 1 | I2S layout select |
| slave_i | input | 1 | 1: frame and bit clocks come from outside |
| thru_i | input | 1 | 1: connect the upstream serial port straight to the outputs |
| mute_i | input | 1 | Word-aligned mute |
| left_i | input | SMP_W | Left sample, two's complement |
| right_i | input | SMP_W | Right sample, two's complement |
| ext_frm_i | input | 1 | External frame clock (slave mode) |
| ext_bck_i | input | 1 | External bit clock (slave mode) |
| in_frm_i | input | 1 | Upstream frame clock (through mode) |
| in_bck_i | input | 1 | Upstream bit clock (through mode) |
| in_dat_i | input | 1 | Upstream serial data (through mode) |
| frm_o | output | 1 | Frame clock |
| bck_o | output | 1 | Bit clock |
| dat_o | output | 1 | Serial data |
| clk_oe_o | output | 1 | High when frm_o and bck_o should drive the shared clock pins |

## Verification
The assertions assume that fmt_i, i2s_i, slave_i and thru_i change only while rst_ni is low. They also assume that, in slave mode, the external bit clock stays in each level for several system clocks and that its frame edges fall on its falling edges. The stimulus changes configuration only under reset. It generates the external clocks from a counter locked to the system clock, at 8 system clocks per bit and 64 bits per frame. Mute and sample inputs are changed only in the middle of a word.

// File: rtl/aout_pkg.sv
package aout_pkg;

  localparam int NARROW_W = 16;

  typedef enum logic [2:0] {
    FMT_RJ16,
    FMT_RJ20,
    FMT_RJ24,
    FMT_LJ16,
    FMT_I2S
  } fmt_e;

  function automatic fmt_e fmt_decode(input logic [1:0] straps, input logic i2s);
    if (i2s) return FMT_I2S;
    case (straps)
      2'b00:   return FMT_RJ16;
      2'b01:   return FMT_RJ20;
      2'b10:   return FMT_RJ24;
      default: return FMT_LJ16;
    endcase
  endfunction

endpackage

// File: rtl/aout_timing.sv
// Word timing: slot events from the internal divider or from synchronized external clocks.
module aout_timing #(
  parameter  int CH_SLOTS    = 32,
  parameter  int SYS_PER_BIT = 8,
  localparam int BIT_LW      = $clog2(SYS_PER_BIT),
  localparam int SL_LW       = $clog2(CH_SLOTS),
  localparam int CNT_W       = BIT_LW + SL_LW + 1,
  localparam int SLOT_BW     = SL_LW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               slave_i,
  input  logic               i2s_i,
  input  logic               ext_frm_i,
  input  logic               ext_bck_i,
  output logic               ev_o,
  output logic [SLOT_BW-1:0] slot_o,
  output logic               ch_o,
  output logic               m_frm_o,
  output logic               m_bck_o
);

  // master divider; resets to all ones so the first edge opens slot 0 of the left word
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             m_ev, m_ch;
  logic [SLOT_BW-1:0] m_slot;

  assign cnt_nx = cnt_q + 1'b1;
  assign m_ev   = (cnt_nx[BIT_LW-1:0] == '0);
  assign m_ch   = cnt_nx[CNT_W-1];
  assign m_slot = {1'b0, cnt_nx[BIT_LW +: SL_LW]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '1;
      m_bck_o <= 1'b0;
      m_frm_o <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      m_bck_o <= ~slave_i & cnt_nx[BIT_LW-1];
      m_frm_o <= ~slave_i & (i2s_i ? m_ch : ~m_ch);
    end
  end

  // slave: synchronize, then count falls since the last channel change
  logic [2:0]         b_sync;
  logic [1:0]         f_sync;
  logic               ch_last_q, s_fall, s_ch;
  logic [SLOT_BW-1:0] s_slot_q, s_slot_nx;

  assign s_fall    = b_sync[2] & ~b_sync[1];
  assign s_ch      = i2s_i ? f_sync[1] : ~f_sync[1];
  assign s_slot_nx = (s_ch != ch_last_q) ? '0 :
                     (&s_slot_q)         ? s_slot_q : s_slot_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_sync    <= '0;
      f_sync    <= '0;
      ch_last_q <= 1'b1;
      s_slot_q  <= '1;
    end else begin
      b_sync <= {b_sync[1:0], ext_bck_i};
      f_sync <= {f_sync[0], ext_frm_i};
      if (slave_i && s_fall) begin
        ch_last_q <= s_ch;
        s_slot_q  <= s_slot_nx;
      end
    end
  end

  assign ev_o   = slave_i ? s_fall    : m_ev;
  assign slot_o = slave_i ? s_slot_nx : m_slot;
  assign ch_o   = slave_i ? s_ch      : m_ch;

endmodule

// File: rtl/aout_mute.sv
// Word-aligned zero forcing: warm-up words after reset, then mute_i sampled per word.
module aout_mute #(
  parameter  int WARM_WORDS = 8,
  localparam int WC_W       = $clog2(WARM_WORDS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic word_start_i,
  input  logic mute_i,
  output logic zero_o
);

  logic [WC_W-1:0] wcnt_q;
  logic            mute_q, warm;

  assign warm   = (wcnt_q < WC_W'(WARM_WORDS));
  assign zero_o = word_start_i ? (mute_i | warm) : mute_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      mute_q <= 1'b1;
    end else if (word_start_i) begin
      mute_q <= mute_i | warm;
      if (warm) wcnt_q <= wcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/aout_shift.sv
// Per-slot bit selection from the latched word; layout set by the decoded format.
module aout_shift import aout_pkg::*; #(
  parameter  int SMP_W    = 20,
  parameter  int MAX_W    = 24,
  parameter  int CH_SLOTS = 32,
  localparam int SL_LW    = $clog2(CH_SLOTS),
  localparam int SLOT_BW  = SL_LW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ev_i,
  input  logic [SLOT_BW-1:0] slot_i,
  input  logic               ch_i,
  input  logic               zero_i,
  input  fmt_e               fmt_i,
  input  logic [SMP_W-1:0]   left_i,
  input  logic [SMP_W-1:0]   right_i,
  output logic               dat_o
);

  logic [SMP_W-1:0]   word_q, cur_w;
  logic [MAX_W-1:0]   aligned, shifted;
  logic [SLOT_BW-1:0] st, wd, off;
  logic               first, vld, bit_nx;

  assign first = (slot_i == '0);
  assign cur_w = first ? (ch_i ? right_i : left_i) : word_q;
  assign aligned = MAX_W'(cur_w) << (MAX_W - SMP_W);

  always_comb begin
    unique case (fmt_i)
      FMT_RJ16: begin st = SLOT_BW'(CH_SLOTS - NARROW_W); wd = SLOT_BW'(NARROW_W); end
      FMT_RJ20: begin st = SLOT_BW'(CH_SLOTS - SMP_W);    wd = SLOT_BW'(SMP_W);    end
      FMT_RJ24: begin st = SLOT_BW'(CH_SLOTS - MAX_W);    wd = SLOT_BW'(MAX_W);    end
      FMT_LJ16: begin st = '0;                            wd = SLOT_BW'(NARROW_W); end
      default:  begin st = SLOT_BW'(1);                   wd = SLOT_BW'(NARROW_W); end
    endcase
  end

  assign off     = slot_i - st;
  assign vld     = (slot_i >= st) && (off < wd) && (slot_i < SLOT_BW'(CH_SLOTS));
  assign shifted = aligned << off;
  assign bit_nx  = vld & ~zero_i & shifted[MAX_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      dat_o  <= 1'b0;
    end else if (ev_i) begin
      dat_o <= bit_nx;
      if (first) word_q <= cur_w;
    end
  end

endmodule

// File: rtl/aout_port.sv
module aout_port import aout_pkg::*; #(
  parameter int SMP_W       = 20,
  parameter int MAX_W       = 24,
  parameter int CH_SLOTS    = 32,
  parameter int SYS_PER_BIT = 8,
  parameter int WARM_WORDS  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       fmt_i,
  input  logic             i2s_i,
  input  logic             slave_i,
  input  logic             thru_i,
  input  logic             mute_i,
  input  logic [SMP_W-1:0] left_i,
  input  logic [SMP_W-1:0] right_i,
  input  logic             ext_frm_i,
  input  logic             ext_bck_i,
  input  logic             in_frm_i,
  input  logic             in_bck_i,
  input  logic             in_dat_i,
  output logic             frm_o,
  output logic             bck_o,
  output logic             dat_o,
  output logic             clk_oe_o
);

  localparam int SLOT_BW = $clog2(CH_SLOTS) + 1;

  fmt_e               fmt;
  logic               ev, ch, zero, m_frm, m_bck, ser_dat;
  logic [SLOT_BW-1:0] slot;

  assign fmt = fmt_decode(fmt_i, i2s_i);

  aout_timing #(.CH_SLOTS(CH_SLOTS), .SYS_PER_BIT(SYS_PER_BIT)) u_timing (
    .clk_i, .rst_ni, .slave_i, .i2s_i, .ext_frm_i, .ext_bck_i,
    .ev_o(ev), .slot_o(slot), .ch_o(ch), .m_frm_o(m_frm), .m_bck_o(m_bck)
  );

  aout_mute #(.WARM_WORDS(WARM_WORDS)) u_mute (
    .clk_i, .rst_ni, .word_start_i(ev && slot == '0), .mute_i, .zero_o(zero)
  );

  aout_shift #(.SMP_W(SMP_W), .MAX_W(MAX_W), .CH_SLOTS(CH_SLOTS)) u_shift (
    .clk_i, .rst_ni, .ev_i(ev), .slot_i(slot), .ch_i(ch), .zero_i(zero),
    .fmt_i(fmt), .left_i, .right_i, .dat_o(ser_dat)
  );

  assign frm_o    = thru_i ? in_frm_i : m_frm;
  assign bck_o    = thru_i ? in_bck_i : m_bck;
  assign dat_o    = thru_i ? (in_dat_i & ~mute_i & rst_ni) : ser_dat;
  assign clk_oe_o = thru_i | ~slave_i;

endmodule

// File: rtl/aout_port_chk.sv
module aout_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic slave_i,
  input logic thru_i,
  input logic mute_i,
  input logic in_bck_i,
  input logic frm_o,
  input logic bck_o,
  input logic dat_o
);

  logic       frm_d, seen;
  logic [8:0] hcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_d <= 1'b0;
      seen  <= 1'b0;
      hcnt  <= '0;
    end else begin
      frm_d <= frm_o;
      if (frm_o != frm_d) begin
        hcnt <= '0;
        seen <= 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni && !thru_i)
      AST_RST_QUIET: assert (!dat_o && !frm_o && !bck_o); // R1
  end

  AST_BCK_HIGH4: assert property (@(posedge clk_i) disable iff (!rst_ni || slave_i || thru_i)
    $rose(bck_o) |=> bck_o ##1 bck_o ##1 bck_o ##1 !bck_o); // R2

  AST_FRM_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni || slave_i || thru_i)
    (frm_o != frm_d && seen) |-> hcnt == 9'd255); // R2

  AST_FRM_BCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni || slave_i || thru_i)
    !$stable(frm_o) |-> !bck_o); // R3

  AST_DAT_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni || slave_i || thru_i)
    !$stable(dat_o) |-> $fell(bck_o)); // R4

  AST_SLAVE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_i && !thru_i) |-> (!frm_o && !bck_o)); // R8

  AST_THRU_BCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thru_i |-> bck_o == in_bck_i); // R9

  AST_THRU_MUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thru_i && mute_i) |-> !dat_o); // R10

endmodule

bind aout_port aout_port_chk u_chk (.*);

// File: tb/aout_port_bench.sv
`timescale 1ns/1ps
module aout_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [1:0]  fmt = 2'b00;
  logic        i2s = 1'b0, slave = 1'b0, thru = 1'b0, mute = 1'b0;
  logic [19:0] left = '0, right = '0;
  logic        ext_frm = 1'b0, ext_bck = 1'b1;
  logic        in_frm = 1'b0, in_bck = 1'b0, in_dat = 1'b0;
  logic        frm_o, bck_o, dat_o, clk_oe_o;
  logic        ext_run = 1'b0;
  logic [8:0]  ext_cnt = '0;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  aout_port u_aout_port (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .i2s_i(i2s), .slave_i(slave),
    .thru_i(thru), .mute_i(mute), .left_i(left), .right_i(right),
    .ext_frm_i(ext_frm), .ext_bck_i(ext_bck), .in_frm_i(in_frm),
    .in_bck_i(in_bck), .in_dat_i(in_dat), .frm_o(frm_o), .bck_o(bck_o),
    .dat_o(dat_o), .clk_oe_o(clk_oe_o)
  );

  // external clock source: 8 system clocks per bit, 64 bits per frame
  always @(posedge clk) begin
    #2;
    if (!ext_run) begin
      ext_cnt = '0;
      ext_bck = 1'b1;
      ext_frm = i2s;
    end else begin
      ext_bck = ext_cnt[2];
      ext_frm = i2s ? ext_cnt[8] : !ext_cnt[8];
      ext_cnt = ext_cnt + 1'b1;
    end
  end

  // receiver: collect 32 slots per channel word at bit clock rises
  logic [31:0] cap [0:63];
  int          cap_n = 0, cur_ch = 1, nb = 0;
  logic [31:0] bits = '0;
  logic        mb_prev = 1'b0;

  always @(negedge clk) begin
    logic mb, mf;
    int   ch;
    mb = slave ? ext_bck : bck_o;
    mf = slave ? ext_frm : frm_o;
    if (!rst_n) begin
      cap_n = 0; cur_ch = 1; nb = 0; bits = '0; mb_prev = mb;
    end else begin
      if (mb && !mb_prev) begin
        ch = (i2s ? mf : !mf) ? 1 : 0;
        if (ch != cur_ch) begin
          if (nb > 0 && cap_n < 64) begin
            cap[cap_n] = bits;
            cap_n++;
          end
          cur_ch = ch; bits = '0; nb = 0;
        end
        if (nb < 32) bits[31-nb] = dat_o;
        nb++;
      end
      mb_prev = mb;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [19:0] s, input int f, input bit i2s_b);
    logic [31:0] r = '0;
    logic [23:0] al = {s, 4'b0};
    int st, w;
    if (i2s_b) begin st = 1; w = 16; end
    else case (f)
      0: begin st = 16; w = 16; end
      1: begin st = 12; w = 20; end
      2: begin st = 8;  w = 24; end
      default: begin st = 0; w = 16; end
    endcase
    for (int slot = 0; slot < 32; slot++) begin
      int k = slot - st;
      if (k >= 0 && k < w) r[31-slot] = al[23-k];
    end
    return r;
  endfunction

  task automatic apply_reset(input int f, input bit i2s_b, input bit slv);
    @(negedge clk);
    rst_n = 1'b0; ext_run = 1'b0; mute = 1'b0; thru = 1'b0;
    fmt = 2'(f); i2s = i2s_b; slave = slv;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    if (slv) ext_run = 1'b1;
  endtask

  task automatic wait_words(input int n);
    while (cap_n < n) @(negedge clk);
  endtask

  task automatic run_fmt(input int f, input bit i2s_b, input bit slv,
                         input logic [19:0] l, input logic [19:0] r);
    logic [31:0] orv = '0;
    string tg;
    left = l; right = r;
    apply_reset(f, i2s_b, slv);
    tg = $sformatf("fmt%0d i2s%0d slave%0d", f, i2s_b, slv);
    wait_words(11);
    for (int i = 0; i < 8; i++) orv |= cap[i];
    chk({"R6 warm-up zero ", tg}, orv, 32'h0);
    chk({"R5 left ", tg}, cap[8], exp_word(l, f, i2s_b));
    chk({"R5 right ", tg}, cap[9], exp_word(r, f, i2s_b));
    chk({"R3 left again ", tg}, cap[10], exp_word(l, f, i2s_b));
    if (slv) chk({"R8 clocks quiet ", tg}, {29'b0, frm_o, bck_o, clk_oe_o}, 32'h0);
    ext_run = 1'b0;
  endtask

  task automatic measure_master;
    logic pf;
    int fh = 0, bh = 0, br = 0;
    logic pb;
    pf = frm_o;
    @(negedge clk);
    while (!(frm_o && !pf)) begin pf = frm_o; @(negedge clk); end
    pb = bck_o;
    for (int i = 0; i < 512; i++) begin
      fh += int'(frm_o);
      bh += int'(bck_o);
      if (bck_o && !pb) br++;
      pb = bck_o;
      pf = frm_o;
      @(negedge clk);
    end
    chk("R2 frame period 512", {30'b0, pf, frm_o}, 32'h1);
    chk("R2 frame high 256", 32'(fh), 32'd256);
    chk("R2 bit clock high 256", 32'(bh), 32'd256);
    chk("R2 bit clock rises 64", 32'(br), 32'd64);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin : main
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {28'b0, frm_o, bck_o, dat_o, clk_oe_o}, 32'h1);

    left = 20'hA5C3F; right = 20'h1357B;
    apply_reset(3, 1'b0, 1'b0);
    measure_master();

    for (int f = 0; f < 4; f++) begin
      run_fmt(f, 1'b0, 1'b0, 20'hA5C3F, 20'h1357B);
      run_fmt(f, 1'b0, 1'b0, 20'h7FFFF, 20'h80001);
    end
    run_fmt(1, 1'b1, 1'b0, 20'hA5C3F, 20'h1357B);
    run_fmt(2, 1'b1, 1'b0, 20'h7FFFF, 20'h80001);

    run_fmt(2, 1'b0, 1'b1, 20'hA5C3F, 20'h1357B);
    run_fmt(0, 1'b1, 1'b1, 20'h7FFFF, 20'h80001);

    // word-aligned mute and start-of-word sample capture, 24-bit right-justified
    left = 20'h12345; right = 20'hFEDCB;
    apply_reset(2, 1'b0, 1'b0);
    wait_words(10);
    repeat (64) @(negedge clk);
    mute = 1'b1; left = 20'h6789A;
    wait_words(13);
    repeat (64) @(negedge clk);
    mute = 1'b0;
    wait_words(16);
    chk("R11 word in progress keeps old sample", cap[10], exp_word(20'h12345, 2, 1'b0));
    chk("R7 mute from next word", cap[11], 32'h0);
    chk("R7 mute held", cap[12], 32'h0);
    chk("R7 release waits for word end", cap[13], 32'h0);
    chk("R7 R11 resume with new sample", cap[14], exp_word(20'h6789A, 2, 1'b0));
    chk("R7 resume right", cap[15], exp_word(20'hFEDCB, 2, 1'b0));

    // through mode
    @(negedge clk);
    rst_n = 1'b0; thru = 1'b1; slave = 1'b0; mute = 1'b0; in_dat = 1'b1; in_frm = 1'b1;
    #1 chk("R10 through data low in reset", {31'b0, dat_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      fmt = v[1:0]; i2s = v[2];
      {in_frm, in_bck, in_dat} = 3'(v);
      #1 chk($sformatf("R9 through pattern %0d", v),
             {28'b0, frm_o, bck_o, dat_o, clk_oe_o}, {28'b0, 3'(v), 1'b1});
    end
    mute = 1'b1;
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      {in_frm, in_bck, in_dat} = 3'(v);
      #1 chk($sformatf("R10 through muted %0d", v),
             {29'b0, frm_o, bck_o, dat_o}, {29'b0, 3'(v & 6)});
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule